// File: doc/BRIEF.md
# Audio Playback Control Register Bank

This block is a small register file that sits between a processor's byte-wide bus and the digital side of an audio output path: a 16-bit DAC and a power-amplifier front end. Software programs a level register (speaker sound-on bit and a 7-bit volume code), a power register (separate DAC and amplifier enables) and two byte registers that together form one 16-bit sample. The block drives the DAC code, both enables, the sound-on control and the volume code straight to the analog blocks.

Sample updates are atomic. A write to the sample's low byte only fills a staging register. The 16-bit DAC code changes in one step when the high byte is written, so the DAC never sees a half-updated code. A sleep input forces both enables off while it is high. The stored enable bits are kept, and they drive the outputs again as soon as sleep is released.

The bus is synchronous. A write is captured on the rising clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `play_ctrl_regs`

## Requirements
- R1: After synchronous reset every output is zero and every register address reads back zero.
- R2: Address 0 is the level register. A write drives `spk_unmute` from bit 7 (1 = sound on, 0 = muted) and `vol_code` from bits 6:0, starting in the cycle after the write edge. A read returns the whole stored byte.
- R3: Address 1 is the power register. Bit 1 is the amplifier enable and bit 0 is the DAC enable. Bits 7:2 are not stored and always read as zero.
- R4: A write to address 2 (sample low byte) leaves `dac_code` unchanged and only updates the staging byte. A read of address 2 returns the staging byte, and the last low write before a high write is the one used.
- R5: A write of value H to address 3 (sample high byte) makes `dac_code` equal {H, staging byte} from the cycle after the write edge. A read of address 3 returns the committed high byte, `dac_code[15:8]`.
- R6: While `sleep_req` is high, `dac_on` and `amp_on` are both 0 in the same cycle. Reads of the power register still return the stored bits, and writes to it still update them.
- R7: When `sleep_req` falls, `dac_on` and `amp_on` return to the stored power bits in the same cycle, without any rewrite.
- R8: With a 3-bit address, addresses 4 to 7 are unmapped. Writes to them change no output and no register, and reads from them return zero.
- R9: A cycle without the write strobe changes no register, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| sleep_req | input | 1 | Low-power request; forces both enables off |
| dac_code | output | 16 | Committed DAC sample code |
| dac_on | output | 1 | DAC enable after sleep gating |
| amp_on | output | 1 | Amplifier enable after sleep gating |
| spk_unmute | output | 1 | Speaker sound-on (1) / mute (0) |
| vol_code | output | 7 | Volume code |

## Verification
Register outputs (level, volume, stored enables, DAC code) change one edge after the write strobe. The bench therefore drives each write on a falling edge, lets one rising edge pass, and samples just after the next falling edge. Read data and the sleep gating are combinational. For these the bench changes the address or `sleep_req` on a falling edge and samples one nanosecond later, well before the next rising edge. The sweeps cover:
- every level value;
- every power-register byte;
- all four enable combinations, both entering and leaving sleep;
- 256 low/high sample pairs;
- every unmapped address.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

    localparam int BYTE_W   = 8;
    localparam int VOL_W    = 7;
    localparam int SAMPLE_W = 2 * BYTE_W;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);

    typedef enum logic [SEL_W-1:0] {
        SEL_LEVEL     = 2'd0,
        SEL_POWER     = 2'd1,
        SEL_SAMPLE_LO = 2'd2,
        SEL_SAMPLE_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             sound_on;
        logic [VOL_W-1:0] level;
    } level_reg_t;

    typedef struct packed {
        logic amp;
        logic dac;
    } power_reg_t;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } decode_t;

    function automatic logic [BYTE_W-1:0] power_to_byte(input power_reg_t p);
        return {{(BYTE_W-2){1'b0}}, p};
    endfunction

    function automatic power_reg_t byte_to_power(input logic [BYTE_W-1:0] b);
        power_reg_t p;
        p.amp = b[1];
        p.dac = b[0];
        return p;
    endfunction

endpackage

// File: rtl/vpc_addr_decode.sv
module vpc_addr_decode
    import vpc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    output decode_t             dec,
    output logic [NUM_REGS-1:0] wr_stb
);

    generate
        if (ADDR_W > SEL_W) begin : g_upper
            assign dec.hit = (addr[ADDR_W-1:SEL_W] == '0);
        end else begin : g_full
            assign dec.hit = 1'b1;
        end
    endgenerate

    assign dec.sel = reg_sel_e'(addr[SEL_W-1:0]);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_stb
        assign wr_stb[g] = we && dec.hit && (dec.sel == reg_sel_e'(SEL_W'(g)));
    end

    // R8: an unmapped address raises no register strobe
    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !dec.hit |-> (wr_stb == '0));

    // R9: without the write strobe no register strobe fires
    p_no_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        !we |-> (wr_stb == '0));

    p_single_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_stb));

endmodule

// File: rtl/vpc_sample_stage.sv
module vpc_sample_stage
    import vpc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-1:0]   staged_lo,
    output logic [SAMPLE_W-1:0] code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_lo <= '0;
        end else if (wr_lo) begin
            staged_lo <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (wr_hi) begin
            code <= {wdata, staged_lo};
        end
    end

    // R4: code holds unless the high byte is written
    p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_hi |=> $stable(code));

    // R5: high write commits the new byte together with the staged low byte
    p_code_commit_r5: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (code == {$past(wdata), $past(staged_lo)}));

endmodule

// File: rtl/vpc_power_ctrl.sv
module vpc_power_ctrl
    import vpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_level,
    input  logic              wr_power,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              sleep,
    output level_reg_t        level_q,
    output power_reg_t        power_q,
    output logic              dac_on,
    output logic              amp_on
);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else if (wr_level) begin
            level_q <= level_reg_t'(wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            power_q <= '0;
        end else if (wr_power) begin
            power_q <= byte_to_power(wdata);
        end
    end

    always_comb begin
        dac_on = power_q.dac && !sleep;
        amp_on = power_q.amp && !sleep;
    end

    // R6: sleep holds both enables off
    p_sleep_off_r6: assert property (@(posedge clk) disable iff (rst)
        sleep |-> (!dac_on && !amp_on));

    // R7: leaving sleep restores the stored enables with no rewrite
    p_wake_restore_r7: assert property (@(posedge clk) disable iff (rst)
        (!sleep && $past(sleep) && !$past(wr_power)) |->
            (dac_on == $past(power_q.dac) && amp_on == $past(power_q.amp)));

    // R2: the level register only moves on its own write
    p_level_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_level |=> $stable(level_q));

endmodule

// File: rtl/play_ctrl_regs.sv
module play_ctrl_regs
    import vpc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                sleep_req,
    output logic [SAMPLE_W-1:0] dac_code,
    output logic                dac_on,
    output logic                amp_on,
    output logic                spk_unmute,
    output logic [VOL_W-1:0]    vol_code
);

    decode_t             dec;
    logic [NUM_REGS-1:0] wr_stb;
    logic [BYTE_W-1:0]   staged_lo;
    level_reg_t          level_q;
    power_reg_t          power_q;

    vpc_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .we     (bus_we),
        .dec    (dec),
        .wr_stb (wr_stb)
    );

    vpc_sample_stage u_sample (
        .clk       (clk),
        .rst       (rst),
        .wr_lo     (wr_stb[SEL_SAMPLE_LO]),
        .wr_hi     (wr_stb[SEL_SAMPLE_HI]),
        .wdata     (bus_wdata),
        .staged_lo (staged_lo),
        .code      (dac_code)
    );

    vpc_power_ctrl u_power (
        .clk      (clk),
        .rst      (rst),
        .wr_level (wr_stb[SEL_LEVEL]),
        .wr_power (wr_stb[SEL_POWER]),
        .wdata    (bus_wdata),
        .sleep    (sleep_req),
        .level_q  (level_q),
        .power_q  (power_q),
        .dac_on   (dac_on),
        .amp_on   (amp_on)
    );

    assign spk_unmute = level_q.sound_on;
    assign vol_code   = level_q.level;

    always_comb begin
        bus_rdata = '0;
        if (dec.hit) begin
            unique case (dec.sel)
                SEL_LEVEL:     bus_rdata = level_q;
                SEL_POWER:     bus_rdata = power_to_byte(power_q);
                SEL_SAMPLE_LO: bus_rdata = staged_lo;
                SEL_SAMPLE_HI: bus_rdata = dac_code[SAMPLE_W-1:BYTE_W];
                default:       bus_rdata = '0;
            endcase
        end
    end

    // R8: unmapped reads return zero
    p_unmapped_read_r8: assert property (@(posedge clk) disable iff (rst)
        ((bus_addr >> SEL_W) != '0) |-> (bus_rdata == '0));

    // R3: unused power bits read zero
    p_power_pad_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(SEL_POWER)) |-> (bus_rdata[BYTE_W-1:2] == '0));

    // R1: outputs are zero right after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (dac_code == '0 && !spk_unmute && vol_code == '0));

endmodule

// File: tb/play_ctrl_regs_tb.sv
module play_ctrl_regs_tb;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          we = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          sleep_req = 1'b0;
    logic [15:0]   dac_code;
    logic          dac_on, amp_on, spk_unmute;
    logic [6:0]    vol_code;

    int n_checks = 0;
    int n_errs   = 0;

    always #4 clk = ~clk;

    play_ctrl_regs #(.ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (addr),
        .bus_we     (we),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .sleep_req  (sleep_req),
        .dac_code   (dac_code),
        .dac_on     (dac_on),
        .amp_on     (amp_on),
        .spk_unmute (spk_unmute),
        .vol_code   (vol_code)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        #1;
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        check(req, {24'd0, rdata}, {24'd0, exp});
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] exp_code;
        logic [7:0]  exp_lo;
        logic [7:0]  snap_lvl, snap_pwr;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check("R1 dac_code", {16'd0, dac_code}, 0);
        check("R1 enables", {30'd0, dac_on, amp_on}, 0);
        check("R1 level", {24'd0, spk_unmute, vol_code}, 0);
        for (int a = 0; a < 4; a++) rd("R1 readback", AW'(a), 8'h00);

        // R2: every level value
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            check("R2 unmute", {31'd0, spk_unmute}, {31'd0, v[7]});
            check("R2 volume", {25'd0, vol_code}, {25'd0, v[6:0]});
            rd("R2 readback", 3'd0, 8'(v));
        end

        // R3: every power byte
        for (int p = 0; p < 256; p++) begin
            wr(3'd1, 8'(p));
            check("R3 dac_on", {31'd0, dac_on}, {31'd0, p[0]});
            check("R3 amp_on", {31'd0, amp_on}, {31'd0, p[1]});
            rd("R3 readback", 3'd1, 8'(p & 3));
        end

        // R6 / R7: sleep gating and restore
        for (int p = 0; p < 4; p++) begin
            wr(3'd1, 8'(p));
            @(negedge clk); sleep_req = 1'b1; #1;
            check("R6 forced off", {30'd0, dac_on, amp_on}, 0);
            rd("R6 stored kept", 3'd1, 8'(p));
            wr(3'd1, 8'(p ^ 3));
            check("R6 off after write", {30'd0, dac_on, amp_on}, 0);
            rd("R6 write in sleep", 3'd1, 8'(p ^ 3));
            @(negedge clk); sleep_req = 1'b0; #1;
            check("R7 restore", {30'd0, amp_on, dac_on}, 32'(p ^ 3));
        end

        // R4 / R5: sample staging and atomic commit
        exp_code = dac_code;
        for (int i = 0; i < 256; i++) begin
            exp_lo = 8'(i);
            wr(3'd2, exp_lo);
            check("R4 code held", {16'd0, dac_code}, {16'd0, exp_code});
            rd("R4 staged read", 3'd2, exp_lo);
            rd("R5 high read", 3'd3, exp_code[15:8]);
            wr(3'd3, 8'(i * 7 + 3));
            exp_code = {8'(i * 7 + 3), exp_lo};
            check("R5 commit", {16'd0, dac_code}, {16'd0, exp_code});
            rd("R5 high read", 3'd3, exp_code[15:8]);
        end
        wr(3'd2, 8'hAA);
        wr(3'd2, 8'h55);
        check("R4 double low held", {16'd0, dac_code}, {16'd0, exp_code});
        wr(3'd3, 8'h12);
        check("R4 last low wins", {16'd0, dac_code}, 32'h1255);
        wr(3'd3, 8'h80);
        check("R5 reuse staged", {16'd0, dac_code}, 32'h8055);

        // R8: unmapped addresses
        wr(3'd0, 8'h9C);
        wr(3'd1, 8'h02);
        snap_lvl = 8'h9C; snap_pwr = 8'h02;
        for (int a = 4; a < 8; a++) begin
            wr(AW'(a), 8'hFF);
            rd("R8 unmapped read", AW'(a), 8'h00);
            check("R8 code", {16'd0, dac_code}, 32'h8055);
            check("R8 outputs", {24'd0, spk_unmute, vol_code}, {24'd0, snap_lvl});
            check("R8 enables", {30'd0, amp_on, dac_on}, {24'd0, snap_pwr});
            rd("R8 level kept", 3'd0, snap_lvl);
            rd("R8 power kept", 3'd1, snap_pwr);
            rd("R8 staged kept", 3'd2, 8'h55);
        end

        // R9: no strobe, no change
        for (int a = 0; a < 8; a++) begin
            @(negedge clk); addr = AW'(a); wdata = 8'hFF; we = 1'b0;
        end
        @(negedge clk); #1;
        check("R9 code", {16'd0, dac_code}, 32'h8055);
        check("R9 level", {24'd0, spk_unmute, vol_code}, {24'd0, snap_lvl});
        check("R9 enables", {30'd0, amp_on, dac_on}, {24'd0, snap_pwr});
        rd("R9 staged", 3'd2, 8'h55);

        // R1: reset mid-run clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R1 code after reset", {16'd0, dac_code}, 0);
        check("R1 outputs after reset", {22'd0, dac_on, amp_on, spk_unmute, vol_code}, 0);
        rd("R1 staged after reset", 3'd2, 8'h00);

        finish_run();
    end
endmodule